// File: doc/BRIEF.md
# Word and Doubleword Rotator

This unit performs right rotations for a 64-bit integer datapath. It turns the raw fields of an already-fetched operation into one of two operation classes. The first class rotates the low 32-bit word and widens the result to 64 bits by copying bit 31. The second class rotates the full 64-bit doubleword. The rotate distance comes from one of two places: the 5-bit shift field of the operation, or the low bits of a value read from a register by the surrounding pipeline.

One immediate doubleword encoding adds 32 to the shift field. This reaches distances of 32 to 63, which a 5-bit field cannot hold on its own. Distances taken from a register are masked: to 5 bits for word rotates and to 6 bits for doubleword rotates. Any field combination that is not a rotate raises an illegal flag and forces the result to zero. The rotation logic is combinational. A parameter either registers the outputs, which gives one cycle of latency, or leaves them combinational.

Top module: `rotr_unit`

## Requirements
- R1: With function field 000010 and selector field 00001, the result is the low 32 bits of the source rotated right by the shift field.
- R2: With function field 000110 and shift field 00001, the low word is rotated right by amount bits 4:0. Amount bit 5 has no effect.
- R3: With function field 111010 and selector field 00001, the full 64-bit source is rotated right by the shift field (0 to 31).
- R4: With function field 111110 and selector field 00001, the 64-bit source is rotated right by the shift field plus 32 (32 to 63).
- R5: With function field 010110 and shift field 00001, the 64-bit source is rotated right by amount bits 5:0.
- R6: Every word-class result has bits 63:32 equal to its bit 31.
- R7: A distance of zero leaves the value unchanged: the full source for the doubleword class, and the sign-widened low word for the word class.
- R8: Every other combination of function, selector and shift fields sets the illegal flag and drives a zero result. Legal combinations clear the flag.
- R9: With the output register on (the default), results and the flag appear one clock after the fields are applied. Reset clears both to zero.
- R10: In the register-distance forms, the selector field may hold any value without changing the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_val | input | 64 | Value to rotate |
| amt_val | input | 6 | Low bits of the register that supplies the distance |
| shf_fld | input | 5 | Shift field of the operation |
| sel_fld | input | 5 | Selector field of the operation (register number in variable forms) |
| fn_fld | input | 6 | Function field of the operation |
| dst_val | output | 64 | Rotated result, zero when illegal |
| bad_op | output | 1 | Set when the fields name no rotate |

## Verification
The bench targets the edges of the distance range.
- It uses the plus-32 encoding at shift 0 and at shift 31. A design that drops the added 32 returns a short rotation or the unchanged value.
- It sets amount bit 5 on a word rotate. A design that fails to mask that bit rotates by the wrong distance.
- It uses word results with bit 31 clear and with bit 31 set. A design that widens without copying bit 31, or that keeps the upper source bits, gives the wrong upper half.
- It uses near-miss encodings, such as a wrong selector or a wrong shift tag. A design that decodes loosely returns a rotated value where it should raise the illegal flag and return zero.

// File: rtl/rotr_pkg.sv
package rotr_pkg;

   localparam int FN_W = 6;

   localparam logic [FN_W-1:0] FN_WORD_IMM   = 6'b000010;
   localparam logic [FN_W-1:0] FN_WORD_VAR   = 6'b000110;
   localparam logic [FN_W-1:0] FN_DWORD_IMM  = 6'b111010;
   localparam logic [FN_W-1:0] FN_DWORD_HI   = 6'b111110;
   localparam logic [FN_W-1:0] FN_DWORD_VAR  = 6'b010110;

   typedef enum logic [1:0] {
      ROT_NONE  = 2'd0,
      ROT_WORD  = 2'd1,
      ROT_DWORD = 2'd2
   } rot_kind_e;

endpackage

// File: rtl/rotr_decode.sv
module rotr_decode
   import rotr_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int HALF_W = DATA_W / 2,
   localparam int AMT_W  = $clog2(DATA_W),
   localparam int SHF_W  = $clog2(HALF_W)
) (
   input  logic [SHF_W-1:0] shf_fld,
   input  logic [SHF_W-1:0] sel_fld,
   input  logic [FN_W-1:0]  fn_fld,
   input  logic [AMT_W-1:0] amt_val,
   output rot_kind_e        kind,
   output logic [AMT_W-1:0] amount
);

   localparam logic [SHF_W-1:0] TAG_ONE = SHF_W'(1);

   logic imm_tag;
   logic var_tag;

   assign imm_tag = (sel_fld == TAG_ONE);
   assign var_tag = (shf_fld == TAG_ONE);

   always_comb begin
      kind   = ROT_NONE;
      amount = '0;
      case (fn_fld)
         FN_WORD_IMM: begin
            if (imm_tag) begin
               kind   = ROT_WORD;
               amount = {1'b0, shf_fld};
            end
         end
         FN_WORD_VAR: begin
            if (var_tag) begin
               kind   = ROT_WORD;
               amount = {1'b0, amt_val[AMT_W-2:0]};
            end
         end
         FN_DWORD_IMM: begin
            if (imm_tag) begin
               kind   = ROT_DWORD;
               amount = {1'b0, shf_fld};
            end
         end
         FN_DWORD_HI: begin
            if (imm_tag) begin
               kind   = ROT_DWORD;
               amount = {1'b1, shf_fld};
            end
         end
         FN_DWORD_VAR: begin
            if (var_tag) begin
               kind   = ROT_DWORD;
               amount = amt_val;
            end
         end
         default: begin
            kind   = ROT_NONE;
            amount = '0;
         end
      endcase
   end

endmodule

// File: rtl/rotr_core.sv
module rotr_core #(
   parameter int W     = 64,
   parameter int STYLE = 0,
   localparam int LW   = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [LW-1:0] amt,
   output logic [W-1:0]  dout
);

   if (W < 4 || (W & (W - 1)) != 0) begin : g_chk_w
      $error("rotr_core: W must be a power of two of at least 4");
   end
   if (STYLE != 0 && STYLE != 1) begin : g_chk_style
      $error("rotr_core: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_log
      logic [W-1:0] stg [0:LW];
      assign stg[0] = din;
      for (genvar s = 0; s < LW; s++) begin : g_stage
         localparam int SH = 1 << s;
         assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
      end
      assign dout = stg[LW];
   end else begin : g_wide
      localparam int unsigned WU = W;
      logic [31:0] back;
      assign back = WU - 32'(amt);
      assign dout = (din >> amt) | (din << back);
   end

   always_comb begin
      AST_BITS_KEPT: assert ($countones(dout) == $countones(din)); // R3
   end

endmodule

// File: rtl/rotr_unit.sv
module rotr_unit
   import rotr_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int REG_OUT   = 1,
   parameter int ROT_STYLE = 0,
   localparam int HALF_W   = DATA_W / 2,
   localparam int AMT_W    = $clog2(DATA_W),
   localparam int SHF_W    = $clog2(HALF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_val,
   input  logic [AMT_W-1:0]  amt_val,
   input  logic [SHF_W-1:0]  shf_fld,
   input  logic [SHF_W-1:0]  sel_fld,
   input  logic [FN_W-1:0]   fn_fld,
   output logic [DATA_W-1:0] dst_val,
   output logic              bad_op
);

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk_w
      $error("rotr_unit: DATA_W must be a power of two of at least 8");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_chk_reg
      $error("rotr_unit: REG_OUT must be 0 or 1");
   end

   rot_kind_e         dec_kind;
   logic [AMT_W-1:0]  dec_amt;
   logic [HALF_W-1:0] w_rot;
   logic [DATA_W-1:0] d_rot;
   logic [DATA_W-1:0] nxt_val;
   logic              nxt_bad;

   rotr_decode #(.DATA_W(DATA_W)) dec_i (
      .shf_fld (shf_fld),
      .sel_fld (sel_fld),
      .fn_fld  (fn_fld),
      .amt_val (amt_val),
      .kind    (dec_kind),
      .amount  (dec_amt)
   );

   rotr_core #(.W(HALF_W), .STYLE(ROT_STYLE)) word_i (
      .din  (src_val[HALF_W-1:0]),
      .amt  (dec_amt[AMT_W-2:0]),
      .dout (w_rot)
   );

   rotr_core #(.W(DATA_W), .STYLE(ROT_STYLE)) dword_i (
      .din  (src_val),
      .amt  (dec_amt),
      .dout (d_rot)
   );

   always_comb begin
      case (dec_kind)
         ROT_WORD:  nxt_val = {{HALF_W{w_rot[HALF_W-1]}}, w_rot};
         ROT_DWORD: nxt_val = d_rot;
         default:   nxt_val = '0;
      endcase
      nxt_bad = (dec_kind == ROT_NONE);
   end

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dst_val <= '0;
            bad_op  <= 1'b0;
         end else begin
            dst_val <= nxt_val;
            bad_op  <= nxt_bad;
         end
      end

      AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         bad_op |-> (dst_val == '0)); // R8
      AST_LEGAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_kind != ROT_NONE) |=> !bad_op); // R8
      AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_kind == ROT_DWORD && dec_amt == '0) |=> (dst_val == $past(src_val))); // R7
      AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_kind == ROT_WORD) |=> (dst_val[DATA_W-1:HALF_W] == {HALF_W{dst_val[HALF_W-1]}})); // R6
   end else begin : g_comb
      assign dst_val = nxt_val;
      assign bad_op  = nxt_bad;
   end

endmodule

// File: tb/rotr_unit_tb_top.sv
module rotr_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 5000;

   typedef struct {
      logic [63:0] val;
      logic        bad;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src_val = '0;
   logic [5:0]  amt_val = '0;
   logic [4:0]  shf_fld = '0;
   logic [4:0]  sel_fld = '0;
   logic [5:0]  fn_fld = '0;
   logic [63:0] dst_val;
   logic        bad_op;

   int   n_cmp = 0;
   int   n_bad = 0;
   exp_t pend [$];
   exp_t fly  [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   rotr_unit dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_val (src_val),
      .amt_val (amt_val),
      .shf_fld (shf_fld),
      .sel_fld (sel_fld),
      .fn_fld  (fn_fld),
      .dst_val (dst_val),
      .bad_op  (bad_op)
   );

   function automatic logic [63:0] rotr(input logic [63:0] x, input int n, input int w);
      logic [63:0] r = '0;
      for (int i = 0; i < w; i++) r[i] = x[(i + n) % w];
      return r;
   endfunction

   function automatic logic [63:0] sext_word(input logic [63:0] x);
      return {{32{x[31]}}, x[31:0]};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [5:0] fn, input logic [4:0] sel, input logic [4:0] shf,
                       input logic [63:0] src, input logic [5:0] amt, input string req);
      exp_t e;
      @(negedge clk);
      fn_fld = fn; sel_fld = sel; shf_fld = shf; src_val = src; amt_val = amt;
      e.bad = 1'b0;
      e.val = '0;
      if (fn == 6'b000010 && sel == 5'd1)      e.val = sext_word(rotr(src, int'(shf), 32));
      else if (fn == 6'b000110 && shf == 5'd1) e.val = sext_word(rotr(src, int'(amt[4:0]), 32));
      else if (fn == 6'b111010 && sel == 5'd1) e.val = rotr(src, int'(shf), 64);
      else if (fn == 6'b111110 && sel == 5'd1) e.val = rotr(src, int'(shf) + 32, 64);
      else if (fn == 6'b010110 && shf == 5'd1) e.val = rotr(src, int'(amt), 64);
      else e.bad = 1'b1;
      e.req = req;
      pend.push_back(e);
   endtask

   always @(posedge clk) begin
      if (pend.size() > 0) fly.push_back(pend.pop_front());
   end

   always @(negedge clk) begin
      if (fly.size() > 0) begin
         exp_t e;
         e = fly.pop_front();
         check(e.req, dst_val, e.val);
         check({e.req, " flag"}, {63'd0, bad_op}, {63'd0, e.bad});
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   localparam logic [63:0] A = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] B = 64'hFFFF_FFFF_1234_5678;
   localparam logic [63:0] C = 64'hDEAD_BEEF_8000_0001;

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset value", dst_val, 64'd0);
      check("R9 reset flag", {63'd0, bad_op}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 word rotate by shift field
      send(6'b000010, 5'd1, 5'd4,  A, 6'd0,  "R1 imm 4");
      send(6'b000010, 5'd1, 5'd31, A, 6'd0,  "R1 imm 31");
      // R2 word rotate by amount, bit 5 ignored; R10 selector ignored
      send(6'b000110, 5'd17, 5'd1, A, 6'h24, "R2 amt bit5 set");
      send(6'b000110, 5'd0,  5'd1, A, 6'h04, "R2 amt 4");
      send(6'b000110, 5'd31, 5'd1, C, 6'd9,  "R10 word var sel 31");
      // R3 doubleword immediate
      send(6'b111010, 5'd1, 5'd13, A, 6'd0,  "R3 imm 13");
      send(6'b111010, 5'd1, 5'd31, C, 6'd0,  "R3 imm 31");
      // R4 plus 32 form
      send(6'b111110, 5'd1, 5'd0,  A, 6'd0,  "R4 hi 32");
      send(6'b111110, 5'd1, 5'd31, A, 6'd0,  "R4 hi 63");
      // R5 doubleword by amount; R10 selector ignored
      send(6'b010110, 5'd9,  5'd1, A, 6'd63, "R5 amt 63");
      send(6'b010110, 5'd22, 5'd1, C, 6'h2A, "R10 dword var sel 22");
      // R6 widening with bit 31 clear and set
      send(6'b000010, 5'd1, 5'd0,  B, 6'd0,  "R6 bit31 clear");
      send(6'b000010, 5'd1, 5'd0,  C, 6'd0,  "R6 bit31 set");
      // R7 zero distance
      send(6'b111010, 5'd1, 5'd0,  C, 6'd0,  "R7 dword imm 0");
      send(6'b010110, 5'd3, 5'd1,  A, 6'd0,  "R7 dword var 0");
      send(6'b000110, 5'd3, 5'd1,  C, 6'h20, "R7 word var 0");
      // R8 near-miss and unrelated encodings
      send(6'b000010, 5'd2, 5'd4,  A, 6'd0,  "R8 word imm bad sel");
      send(6'b000110, 5'd1, 5'd0,  A, 6'd5,  "R8 word var bad tag");
      send(6'b111010, 5'd0, 5'd7,  A, 6'd0,  "R8 dword imm bad sel");
      send(6'b111111, 5'd1, 5'd1,  A, 6'd0,  "R8 unknown fn");
      send(6'b010110, 5'd1, 5'd3,  A, 6'd5,  "R8 dword var bad tag");
      send(6'b111110, 5'd1, 5'd5,  C, 6'd0,  "R8 legal after illegal");
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule